// File: doc/BRIEF.md
# Indirect Subport Register Bank

This block is a peripheral port that occupies one module address on a nibble-wide I/O bus and holds a bank of up to sixteen registers, called subports. Software reaches a subport in two steps. It first writes the subport's index to the module address, then it issues one or two data accesses to the same address. An internal phase machine tracks which step comes next, so a single bus address serves the whole bank.

Each subport is either narrow (4 bits) or wide (8 bits), as set by a per-subport configuration input. A wide subport moves as two nibbles. On a write the low nibble goes first. On a read the high nibble comes back first. A wide write commits the whole byte only when its second nibble arrives. A wide read captures the byte when its first nibble is read, so both returned nibbles belong to the same value.

Top module: `subport_bank`

## Requirements
- R1: A synchronous reset (`rst` high) clears the subport index to 0, clears every subport register to 0, clears `io_rdata` to 0 and puts the block in the index phase.
- R2: A cycle is an access only when `io_stb` is 1 and `io_addr` equals the parameter `MOD_ADDR` (default 4'h6). Other cycles change no state and leave `io_rdata` unchanged.
- R3: In the index phase, an OUT (`io_wr`=1) loads `io_wdata` into the subport index and moves to the data phase. An IN (`io_wr`=0) returns the current index on `io_rdata` and stays in the index phase.
- R4: For a narrow subport (`wide_cfg[i]`=0), one data-phase OUT stores `io_wdata` in the register with its upper nibble cleared, and the block returns to the index phase.
- R5: For a narrow subport, one data-phase IN returns the register's low nibble, and the block returns to the index phase.
- R6: For a wide subport (`wide_cfg[i]`=1), a write is two OUTs, low nibble first and then high nibble. The register changes only on the second OUT, which loads both nibbles at once. The block then returns to the index phase.
- R7: For a wide subport, a read is two INs. The first IN returns bits [7:4] and captures the byte. The second IN returns bits [3:0] of the captured byte. The block then returns to the index phase.
- R8: An access in the wrong direction during the second nibble of a wide transfer abandons that transfer. No register is written, and the block returns to the index phase. If the stray access is an IN, it returns 0.
- R9: `io_rdata` is registered. It shows the result of an IN from the clock edge that samples the IN, and it holds its value through every cycle that is not an IN access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_stb | input | 1 | Bus access strobe, one cycle per access |
| io_wr | input | 1 | 1 = OUT (write), 0 = IN (read) |
| io_addr | input | 4 | Module address on the bus |
| io_wdata | input | 4 | Write nibble |
| wide_cfg | input | 16 | Bit i set makes subport i 8 bits wide |
| io_rdata | output | 4 | Registered read nibble |

## Verification
The bench checks the opposite nibble orders of wide writes and wide reads. A design that used one order for both would return the two nibbles of a byte swapped. It also interrupts a wide write after its low nibble and then reads the register back. A design that wrote the low nibble straight into the register would show a torn byte, and one that did not leave the data phase would treat the next index write as data. IN accesses in the index phase, together with accesses to a foreign address and accesses with the strobe low, show whether the phase machine advances when it must not. Reads of subports that were never written confirm the values after reset.

// File: rtl/subport_pkg.sv
package subport_pkg;
  typedef enum logic [1:0] {
    PH_INDEX  = 2'd0,   // next OUT is a subport index
    PH_DATA   = 2'd1,   // first data access
    PH_WR_HI  = 2'd2,   // wide write, waiting for high nibble
    PH_RD_LO  = 2'd3    // wide read, waiting to hand out low nibble
  } phase_t;
endpackage

// File: rtl/subport_regs.sv
module subport_regs #(
  parameter int NUM_SUB = 16,
  parameter int WORD_W  = 8,
  localparam int SEL_W  = $clog2(NUM_SUB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] rword
);
  logic [WORD_W-1:0] bank_q [NUM_SUB];

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        bank_q[g] <= '0;
      else if (we && (sel == SEL_W'(g)))
        bank_q[g] <= wword;
    end
  end

  assign rword = bank_q[sel];
endmodule

// File: rtl/subport_seq.sv
module subport_seq
  import subport_pkg::*;
#(
  parameter int NUM_SUB = 16,
  parameter int NIB_W   = 4,
  localparam int SEL_W  = $clog2(NUM_SUB),
  localparam int WORD_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              wr,
  input  logic [NIB_W-1:0]  wdata,
  input  logic [NUM_SUB-1:0] wide_cfg,
  input  logic [WORD_W-1:0] rword,
  output phase_t            phase,
  output logic [SEL_W-1:0]  sel,
  output logic              we,
  output logic [WORD_W-1:0] wword,
  output logic [NIB_W-1:0]  rdata
);
  logic [NIB_W-1:0] lo_q;     // pending low nibble of a wide write
  logic [NIB_W-1:0] rd_lo_q;  // captured low nibble of a wide read
  logic             wide;

  assign wide = wide_cfg[sel];

  always_comb begin
    we    = 1'b0;
    wword = {{NIB_W{1'b0}}, wdata};
    if (hit && wr) begin
      if (phase == PH_DATA && !wide) we = 1'b1;
      if (phase == PH_WR_HI) begin
        we    = 1'b1;
        wword = {wdata, lo_q};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_INDEX;
      sel     <= '0;
      lo_q    <= '0;
      rd_lo_q <= '0;
      rdata   <= '0;
    end else if (hit) begin
      unique case (phase)
        PH_INDEX: begin
          if (wr) begin
            sel   <= wdata[SEL_W-1:0];
            phase <= PH_DATA;
          end else begin
            rdata <= NIB_W'(sel);
          end
        end
        PH_DATA: begin
          if (wr) begin
            if (wide) begin
              lo_q  <= wdata;
              phase <= PH_WR_HI;
            end else begin
              phase <= PH_INDEX;
            end
          end else if (wide) begin
            rd_lo_q <= rword[NIB_W-1:0];
            rdata   <= rword[WORD_W-1:NIB_W];
            phase   <= PH_RD_LO;
          end else begin
            rdata <= rword[NIB_W-1:0];
            phase <= PH_INDEX;
          end
        end
        PH_WR_HI: begin
          phase <= PH_INDEX;
          if (!wr) rdata <= '0;
        end
        PH_RD_LO: begin
          phase <= PH_INDEX;
          if (!wr) rdata <= rd_lo_q;
        end
        default: phase <= PH_INDEX;
      endcase
    end
  end
endmodule

// File: rtl/subport_bank.sv
module subport_bank
  import subport_pkg::*;
#(
  parameter int          NUM_SUB  = 16,
  parameter int          NIB_W    = 4,
  parameter int          ADDR_W   = 4,
  parameter logic [3:0]  MOD_ADDR = 4'h6,
  localparam int         SEL_W    = $clog2(NUM_SUB),
  localparam int         WORD_W   = 2 * NIB_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               io_stb,
  input  logic               io_wr,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic [NIB_W-1:0]   io_wdata,
  input  logic [NUM_SUB-1:0] wide_cfg,
  output logic [NIB_W-1:0]   io_rdata
);
  logic              hit;
  phase_t            phase;
  logic [SEL_W-1:0]  sel;
  logic              we;
  logic [WORD_W-1:0] wword, rword;

  assign hit = io_stb && (io_addr == ADDR_W'(MOD_ADDR));

  subport_seq #(.NUM_SUB(NUM_SUB), .NIB_W(NIB_W)) seq_i (
    .clk(clk), .rst(rst), .hit(hit), .wr(io_wr), .wdata(io_wdata),
    .wide_cfg(wide_cfg), .rword(rword), .phase(phase), .sel(sel),
    .we(we), .wword(wword), .rdata(io_rdata)
  );

  subport_regs #(.NUM_SUB(NUM_SUB), .WORD_W(WORD_W)) regs_i (
    .clk(clk), .rst(rst), .we(we), .sel(sel), .wword(wword), .rword(rword)
  );
endmodule

// File: rtl/subport_bank_chk.sv
module subport_bank_chk
  import subport_pkg::*;
#(
  parameter int NUM_SUB = 16,
  parameter int NIB_W   = 4,
  localparam int SEL_W  = $clog2(NUM_SUB)
) (
  input logic               clk,
  input logic               rst,
  input logic               hit,
  input logic               io_wr,
  input logic [NUM_SUB-1:0] wide_cfg,
  input phase_t             phase,
  input logic [SEL_W-1:0]   sel,
  input logic [NIB_W-1:0]   io_rdata
);
  // R2 and R9: rdata moves only on an IN access
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(hit && !io_wr) |=> $stable(io_rdata));

  // R2: a cycle that is not an access leaves the phase alone
  a_r2_no_hit_phase: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(phase) && $stable(sel));

  // R3: IN in the index phase returns the index and does not advance
  a_r3_index_in: assert property (@(posedge clk) disable iff (rst)
    (hit && !io_wr && phase == PH_INDEX)
      |=> (phase == PH_INDEX) && (io_rdata == NIB_W'($past(sel))));

  // R4: a narrow write ends the transfer
  a_r4_narrow_done: assert property (@(posedge clk) disable iff (rst)
    (hit && io_wr && phase == PH_DATA && !wide_cfg[sel]) |=> phase == PH_INDEX);

  // R7: a wide read goes on to the low-nibble step
  a_r7_wide_rd_step: assert property (@(posedge clk) disable iff (rst)
    (hit && !io_wr && phase == PH_DATA && wide_cfg[sel]) |=> phase == PH_RD_LO);

  // R8: an IN during a wide write abandons it and returns 0
  a_r8_abort_in: assert property (@(posedge clk) disable iff (rst)
    (hit && !io_wr && phase == PH_WR_HI) |=> (phase == PH_INDEX) && (io_rdata == '0));
endmodule

bind subport_bank subport_bank_chk #(.NUM_SUB(NUM_SUB), .NIB_W(NIB_W)) chk_i (
  .clk(clk), .rst(rst), .hit(hit), .io_wr(io_wr), .wide_cfg(wide_cfg),
  .phase(phase), .sel(sel), .io_rdata(io_rdata)
);

// File: tb/subport_bank_tb_top.sv
module subport_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_stb = 1'b0;
  logic        io_wr = 1'b0;
  logic [3:0]  io_addr = 4'h0;
  logic [3:0]  io_wdata = 4'h0;
  logic [15:0] wide_cfg = 16'h00F0;   // subports 4..7 are wide
  logic [3:0]  io_rdata;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  subport_bank dut_i (
    .clk(clk), .rst(rst), .io_stb(io_stb), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .wide_cfg(wide_cfg), .io_rdata(io_rdata)
  );

  // vector: {check, wr, addr[3:0], data[3:0]}; for IN, data = expected io_rdata
  localparam int NV = 24;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0,1'b1,4'h6,4'h3},  // index 3 (narrow)
    {1'b0,1'b1,4'h6,4'hA},  // R4 narrow write A
    {1'b0,1'b1,4'h6,4'h3},
    {1'b1,1'b0,4'h6,4'hA},  // R5 narrow read
    {1'b1,1'b0,4'h6,4'h3},  // R3 index-phase IN returns index
    {1'b0,1'b1,4'h6,4'h5},  // index 5 (wide)
    {1'b0,1'b1,4'h6,4'hC},  // R6 low nibble
    {1'b0,1'b1,4'h6,4'h7},  // R6 high nibble -> 7C
    {1'b0,1'b1,4'h6,4'h5},
    {1'b1,1'b0,4'h6,4'h7},  // R7 high first
    {1'b1,1'b0,4'h6,4'hC},  // R7 low second
    {1'b1,1'b0,4'h6,4'h5},  // R6 back in index phase
    {1'b0,1'b1,4'h2,4'h9},  // R2 foreign address OUT
    {1'b1,1'b0,4'h6,4'h5},  // R2 index unchanged
    {1'b0,1'b1,4'h6,4'h5},
    {1'b0,1'b1,4'h6,4'h1},  // wide low nibble
    {1'b1,1'b0,4'h6,4'h0},  // R8 IN abandons, returns 0
    {1'b0,1'b1,4'h6,4'h5},
    {1'b1,1'b0,4'h6,4'h7},  // R6 register untouched by abandoned write
    {1'b1,1'b0,4'h6,4'hC},
    {1'b0,1'b1,4'h6,4'h4},  // index 4 (wide, never written)
    {1'b1,1'b0,4'h6,4'h0},  // R1 cleared high
    {1'b1,1'b0,4'h6,4'h0},  // R1 cleared low
    {1'b1,1'b0,4'h6,4'h4}   // R3 index readback
  };

  task automatic acc(input logic stb, input logic wr, input logic [3:0] a,
                     input logic [3:0] d);
    @(negedge clk);
    io_stb = stb; io_wr = wr; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_stb = 1'b0;
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    total++;
    if (io_rdata !== exp) begin
      bad++;
      $display("FAIL %s: io_rdata=%h expected=%h", req, io_rdata, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", 4'h0);                    // reset value of io_rdata
    acc(1'b1, 1'b0, 4'h6, 4'h0);
    chk("R1", 4'h0);                    // index reset to 0

    for (int i = 0; i < NV; i++) begin
      acc(1'b1, VEC[i][8], VEC[i][7:4], VEC[i][3:0]);
      if (VEC[i][9]) chk($sformatf("vec%0d", i), VEC[i][3:0]);
    end

    // R9: idle cycles hold io_rdata
    repeat (4) @(negedge clk);
    chk("R9", 4'h4);

    // R2: strobe low at own address does not load an index
    acc(1'b0, 1'b1, 4'h6, 4'h9);
    acc(1'b1, 1'b0, 4'h6, 4'h0);
    chk("R2", 4'h4);

    // R8: OUT during wide read abandons it, nothing written
    acc(1'b1, 1'b1, 4'h6, 4'h5);
    acc(1'b1, 1'b0, 4'h6, 4'h0);
    chk("R7", 4'h7);
    acc(1'b1, 1'b1, 4'h6, 4'hE);        // stray OUT
    acc(1'b1, 1'b0, 4'h6, 4'h0);        // index phase again
    chk("R8", 4'h5);

    // R4: narrow write clears upper nibble, read back of wide-marked stays separate
    acc(1'b1, 1'b1, 4'h6, 4'hF);
    acc(1'b1, 1'b1, 4'h6, 4'h9);
    acc(1'b1, 1'b1, 4'h6, 4'hF);
    acc(1'b1, 1'b0, 4'h6, 4'h0);
    chk("R4", 4'h9);

    // R1: reset clears written registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1", 4'h0);
    acc(1'b1, 1'b1, 4'h6, 4'h3);
    acc(1'b1, 1'b0, 4'h6, 4'h0);
    chk("R1", 4'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule